// File: doc/BRIEF.md
# Unaligned Load-Left Merge Unit

This datapath block computes the left half of an unaligned 32-bit load on a machine with 64-bit registers. An operation brings a base register value, a small signed displacement, the current contents of the destination register, endianness controls, permission enables and one aligned 64-bit memory beat. The block forms the effective address, picks the 32-bit half of the beat and the byte position within it, and merges the upper bytes of the unaligned word into the destination's low word. It then replicates bit 31 across the upper 32 bits.

Depending on where the address falls, the memory supplies between one and four bytes. These fill the most-significant end of the low word. The bytes below them keep the old register contents. A following right-hand load completes the word. To support that pairing, the block can feed its own result back as the old register value when the next operation names the same destination.

The result sits in an output register behind a valid/ready handshake. Two permission conditions turn an operation into a fault. A faulted operation passes the old value through unchanged.

Top module: `ulm_left_merge`

## Requirements
- R1: `mem_addr` bits XLEN-1:3 equal the effective address, which is `in_base` plus `in_ofs` sign-extended to XLEN bits. The sum wraps modulo 2^XLEN.
- R2: Bits 2:0 of `mem_addr` are 000 when `mem_be` is 0. When `mem_be` is 1 they are the effective address bits 2:0 XORed with `rev_end` in all three positions.
- R3: The word taken from `in_beat` is bits 63:32 when (effective address bit 2 XOR `cpu_be`) is 1. Otherwise it is bits 31:0.
- R4: Let k = effective address bits 1:0 XOR {`cpu_be`,`cpu_be`}. The merged low word places word bits 8k+7:0 at positions 31:24-8k and keeps old bits 23-8k:0. When k=3 all 32 bits come from memory.
- R5: For a non-faulted result, `out_data` bits XLEN-1:32 all equal `out_data` bit 31.
- R6: `in_ready` is high when `out_valid` is low or `out_ready` is high. An accepted operation's result appears on `out_*` after the next rising clock edge. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_dst` and the fault flags hold.
- R7: With `legacy_en` low, the result has `out_ri`=1 and `out_cu`=0. With `legacy_en` high and `cp0_en` low, it has `out_cu`=1 and `out_ri`=0. A faulted result carries the old register value unchanged. At most one fault flag is ever set.
- R8: Forwarding applies when an operation is accepted while `out_valid` is high, the held result is not faulted, and `in_dst` equals `out_dst`. In that case the held `out_data` is used as the old register value and `in_old` has no effect.
- R9: After reset `out_valid`, `out_ri` and `out_cu` are 0.
- R10: No byte offset, aligned or not, raises a fault when both `legacy_en` and `cp0_en` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_base | input | XLEN | Base register value |
| in_ofs | input | OFS_W | Signed displacement |
| in_old | input | XLEN | Current destination register value |
| in_dst | input | IDX_W | Destination register index |
| in_beat | input | 64 | Aligned memory beat for this operation |
| cpu_be | input | 1 | Core runs big-endian |
| rev_end | input | 1 | Reverse-endian mode for the running context |
| mem_be | input | 1 | Memory is big-endian |
| cp0_en | input | 1 | System-control access permitted |
| legacy_en | input | 1 | Unaligned left/right loads implemented |
| mem_addr | output | XLEN | Address presented to memory (combinational) |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | XLEN | Merged, sign-extended register value |
| out_dst | output | IDX_W | Destination register index of the result |
| out_ri | output | 1 | Reserved-instruction fault |
| out_cu | output | 1 | Coprocessor-unusable fault |

## Verification
The bench builds the block with its defaults: 64-bit registers, a 9-bit displacement, 5-bit register indices and forwarding enabled. With only a 9-bit displacement, every low-order address pattern and the wrap of negative displacements below small bases are within reach. With forwarding compiled in, left-then-right chains to one destination can be exercised. The bench steers destinations to a small set so that forwarding hits, stalls under a blocked consumer and faulted predecessors interleave often.

// File: rtl/ulm_pkg.sv
package ulm_pkg;
   localparam int WORD_W = 32;
   localparam int BYTE_W = 8;
   localparam int LANES  = WORD_W / BYTE_W;
   localparam int BEAT_W = 2 * WORD_W;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_RSVD = 2'd1,
      FLT_COPU = 2'd2
   } ulm_fault_e;
endpackage

// File: rtl/ulm_addr_gen.sv
module ulm_addr_gen #(
   parameter int XLEN  = 64,
   parameter int OFS_W = 9
) (
   input  logic [XLEN-1:0]  base,
   input  logic [OFS_W-1:0] ofs,
   input  logic             cpu_be,
   input  logic             rev_end,
   input  logic             mem_be,
   output logic [XLEN-1:0]  ea,
   output logic [XLEN-1:0]  pa,
   output logic [1:0]       byte_idx,
   output logic             half_sel
);
   localparam int EXT_W = XLEN - OFS_W;

   logic [XLEN-1:0] ofs_ext;
   logic [2:0]      pa_lo;

   assign ofs_ext  = {{EXT_W{ofs[OFS_W-1]}}, ofs};
   assign ea       = base + ofs_ext;
   assign byte_idx = ea[1:0] ^ {2{cpu_be}};
   assign half_sel = ea[2] ^ cpu_be;

   always_comb begin
      if (mem_be) pa_lo = ea[2:0] ^ {3{rev_end}};
      else        pa_lo = 3'b000;
   end

   assign pa = {ea[XLEN-1:3], pa_lo};
endmodule

// File: rtl/ulm_byte_merge.sv
module ulm_byte_merge
   import ulm_pkg::*;
(
   input  logic [BEAT_W-1:0] beat,
   input  logic              half_sel,
   input  logic [1:0]        byte_idx,
   input  logic [WORD_W-1:0] old_lo,
   output logic [WORD_W-1:0] merged
);
   logic [WORD_W-1:0] word;

   assign word = half_sel ? beat[BEAT_W-1:WORD_W] : beat[WORD_W-1:0];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [2:0] pos;
      logic [1:0] src;
      logic       take;

      assign pos  = {1'b0, byte_idx} + 3'(k);
      assign take = (pos >= 3'(LANES - 1));
      assign src  = 2'(pos - 3'(LANES - 1));

      always_comb begin
         if (take) merged[BYTE_W*k +: BYTE_W] = word[BYTE_W*src +: BYTE_W];
         else      merged[BYTE_W*k +: BYTE_W] = old_lo[BYTE_W*k +: BYTE_W];
      end
   end
endmodule

// File: rtl/ulm_left_merge.sv
module ulm_left_merge
   import ulm_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int OFS_W  = 9,
   parameter int IDX_W  = 5,
   parameter bit FWD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [XLEN-1:0]   in_base,
   input  logic [OFS_W-1:0]  in_ofs,
   input  logic [XLEN-1:0]   in_old,
   input  logic [IDX_W-1:0]  in_dst,
   input  logic [63:0]       in_beat,
   input  logic              cpu_be,
   input  logic              rev_end,
   input  logic              mem_be,
   input  logic              cp0_en,
   input  logic              legacy_en,
   output logic [XLEN-1:0]   mem_addr,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [XLEN-1:0]   out_data,
   output logic [IDX_W-1:0]  out_dst,
   output logic              out_ri,
   output logic              out_cu
);
   localparam int HI_W = XLEN - WORD_W;

   if (XLEN < BEAT_W) begin : g_bad_xlen
      $error("ulm_left_merge: XLEN must be at least 64");
   end
   if (OFS_W < 3 || OFS_W >= XLEN) begin : g_bad_ofs
      $error("ulm_left_merge: OFS_W out of range");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("ulm_left_merge: IDX_W must be positive");
   end

   logic [XLEN-1:0]   ea;
   logic [1:0]        byte_idx;
   logic              half_sel;
   logic [XLEN-1:0]   old_eff;
   logic [WORD_W-1:0] merged;
   logic [XLEN-1:0]   result;
   ulm_fault_e        fault;
   logic              accept;

   logic              r_valid;
   logic [XLEN-1:0]   r_data;
   logic [IDX_W-1:0]  r_dst;
   ulm_fault_e        r_fault;

   ulm_addr_gen #(.XLEN(XLEN), .OFS_W(OFS_W)) u_addr (
      .base     (in_base),
      .ofs      (in_ofs),
      .cpu_be   (cpu_be),
      .rev_end  (rev_end),
      .mem_be   (mem_be),
      .ea       (ea),
      .pa       (mem_addr),
      .byte_idx (byte_idx),
      .half_sel (half_sel)
   );

   if (FWD_EN) begin : g_fwd
      logic hit;
      assign hit     = r_valid && (r_fault == FLT_NONE) && (r_dst == in_dst);
      assign old_eff = hit ? r_data : in_old;
   end else begin : g_nofwd
      assign old_eff = in_old;
   end

   ulm_byte_merge u_merge (
      .beat     (in_beat),
      .half_sel (half_sel),
      .byte_idx (byte_idx),
      .old_lo   (old_eff[WORD_W-1:0]),
      .merged   (merged)
   );

   always_comb begin
      if (!legacy_en)  fault = FLT_RSVD;
      else if (!cp0_en) fault = FLT_COPU;
      else              fault = FLT_NONE;
   end

   assign result   = (fault == FLT_NONE) ? {{HI_W{merged[WORD_W-1]}}, merged} : old_eff;
   assign in_ready = !r_valid || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_valid <= 1'b0;
         r_data  <= '0;
         r_dst   <= '0;
         r_fault <= FLT_NONE;
      end else begin
         if (accept) begin
            r_valid <= 1'b1;
            r_data  <= result;
            r_dst   <= in_dst;
            r_fault <= fault;
         end else if (out_ready) begin
            r_valid <= 1'b0;
         end
      end
   end

   assign out_valid = r_valid;
   assign out_data  = r_data;
   assign out_dst   = r_dst;
   assign out_ri    = (r_fault == FLT_RSVD);
   assign out_cu    = (r_fault == FLT_COPU);

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_dst)));

   assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid);

   assert_fault_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $onehot0({out_ri, out_cu}));

   assert_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ri && !out_cu) |-> (out_data[XLEN-1:WORD_W] == {HI_W{out_data[WORD_W-1]}}));

   assert_keep_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && legacy_en && cp0_en && byte_idx == 2'd0) |=> (out_data[23:0] == $past(old_eff[23:0])));

   assert_no_misalign_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && legacy_en && cp0_en) |=> (!out_ri && !out_cu));
endmodule

// File: tb/ulm_left_merge_bench.sv
module ulm_left_merge_bench;
   localparam int XLEN = 64;
   localparam int OFS_W = 9;
   localparam int IDX_W = 5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [XLEN-1:0]  in_base = '0;
   logic [OFS_W-1:0] in_ofs = '0;
   logic [XLEN-1:0]  in_old = '0;
   logic [IDX_W-1:0] in_dst = '0;
   logic [63:0]      in_beat = '0;
   logic             cpu_be = 1'b0, rev_end = 1'b0, mem_be = 1'b0;
   logic             cp0_en = 1'b1, legacy_en = 1'b1;
   logic [XLEN-1:0]  mem_addr;
   logic             out_valid;
   logic             out_ready = 1'b1;
   logic [XLEN-1:0]  out_data;
   logic [IDX_W-1:0] out_dst;
   logic             out_ri, out_cu;

   ulm_left_merge u_ulm_left_merge (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_base(in_base), .in_ofs(in_ofs), .in_old(in_old), .in_dst(in_dst),
      .in_beat(in_beat), .cpu_be(cpu_be), .rev_end(rev_end), .mem_be(mem_be),
      .cp0_en(cp0_en), .legacy_en(legacy_en), .mem_addr(mem_addr),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_dst(out_dst), .out_ri(out_ri), .out_cu(out_cu)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_ea(logic [63:0] b, logic [OFS_W-1:0] o);
      longint signed d;
      d = longint'($signed(o));
      return b + 64'(d);
   endfunction

   function automatic logic [63:0] ref_addr(logic [63:0] e, logic rv, logic mb);
      logic [63:0] a;
      a = e;
      if (!mb) a[2:0] = 3'b000;
      else     a[2:0] = e[2:0] ^ (rv ? 3'b111 : 3'b000);
      return a;
   endfunction

   function automatic logic [31:0] ref_merge(logic [63:0] e, logic be, logic [63:0] beat,
                                             logic [31:0] old);
      int k;
      logic [31:0] w, keep;
      k = int'(e[1:0] ^ {be, be});
      w = (e[2] ^ be) ? beat[63:32] : beat[31:0];
      keep = 32'hFFFFFF >> (8 * k);
      return (w << (24 - 8 * k)) | (old & keep);
   endfunction

   // behavioural model of the output register
   logic             m_valid = 1'b0;
   logic [63:0]      m_data = '0;
   logic [IDX_W-1:0] m_dst = '0;
   logic             m_ri = 1'b0, m_cu = 1'b0;

   always @(posedge clk) begin
      logic [63:0] old_v, e;
      logic [31:0] lo;
      logic        tk;
      if (!rst_n) begin
         m_valid <= 1'b0; m_ri <= 1'b0; m_cu <= 1'b0;
      end else begin
         tk = in_valid && (!m_valid || out_ready);
         if (tk) begin
            old_v = (m_valid && !m_ri && !m_cu && m_dst == in_dst) ? m_data : in_old;
            e = ref_ea(in_base, in_ofs);
            m_valid <= 1'b1;
            m_dst   <= in_dst;
            m_ri    <= !legacy_en;
            m_cu    <= legacy_en && !cp0_en;
            if (legacy_en && cp0_en) begin
               lo = ref_merge(e, cpu_be, in_beat, old_v[31:0]);
               m_data <= {{32{lo[31]}}, lo};
            end else begin
               m_data <= old_v;
            end
         end else if (out_ready) begin
            m_valid <= 1'b0;
         end
      end
   end

   task automatic cycle_check();
      chk("R1,R2 mem_addr", mem_addr, ref_addr(ref_ea(in_base, in_ofs), rev_end, mem_be));
      chk("R6 in_ready", 64'(in_ready), 64'(!m_valid || out_ready));
      chk("R6 out_valid", 64'(out_valid), 64'(m_valid));
      if (m_valid) begin
         chk("R6 out_dst", 64'(out_dst), 64'(m_dst));
         chk("R7,R10 faults", {62'b0, out_ri, out_cu}, {62'b0, m_ri, m_cu});
         if (m_ri || m_cu) chk("R7 data passthrough", out_data, m_data);
         else begin
            chk("R3,R4,R8 data", out_data, m_data);
            chk("R5 sign copy", out_data[63:32], {32{out_data[31]}});
         end
      end
   endtask

   task automatic op(logic v, logic [63:0] b, logic [OFS_W-1:0] o, logic [63:0] old,
                     logic [IDX_W-1:0] d, logic [63:0] bt, logic be, logic rv, logic mb,
                     logic c0, logic lg, logic ordy);
      @(negedge clk);
      cycle_check();
      in_valid = v; in_base = b; in_ofs = o; in_old = old; in_dst = d; in_beat = bt;
      cpu_be = be; rev_end = rv; mem_be = mb; cp0_en = c0; legacy_en = lg; out_ready = ordy;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 out_valid", 64'(out_valid), 64'd0);
      chk("R9 faults", {62'b0, out_ri, out_cu}, 64'd0);
      rst_n = 1'b1;

      // R3 R4 R10: every byte offset in both core byte orders, both memory orders
      for (int be = 0; be < 2; be++)
         for (int off = 0; off < 8; off++)
            op(1'b1, 64'h4000, OFS_W'(off), 64'hA5A5A5A5_5A5A5A5A, 5'd9,
               64'h8899AABB_11223344, be[0], off[0], off[1], 1'b1, 1'b1, 1'b1);

      // R1: negative displacement wrapping below zero
      op(1'b1, 64'h2, 9'h1F0, 64'h0, 5'd1, 64'hF0E0D0C0_B0A09080, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
      // R5: full-word take with sign bit set
      op(1'b1, 64'h3, 9'h0, 64'h0, 5'd2, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      op(1'b1, 64'h3, 9'h0, 64'h0, 5'd3, 64'h00000000_80000001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);

      // R8: directed forwarding pair into register 7
      op(1'b1, 64'h1000, 9'h0, 64'hAAAAAAAA_BBCCDDEE, 5'd7, 64'h0_11223344, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      op(1'b1, 64'h1000, 9'h1, 64'hFFFFFFFF_FFFF0000, 5'd7, 64'h0_11223344, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      op(1'b0, 64'h0, 9'h0, 64'h0, 5'd0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      chk("R8 forwarded merge", out_data, 64'h00000000_3344DDEE);

      // R6: stall, offered op must wait and result must hold
      op(1'b1, 64'h10, 9'h0, 64'h1, 5'd4, 64'h77, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      op(1'b1, 64'h20, 9'h3, 64'h2, 5'd5, 64'h99, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      op(1'b1, 64'h20, 9'h3, 64'h2, 5'd5, 64'h99, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      chk("R6 held while blocked", 64'(out_dst), 64'd4);

      // R7: both fault kinds, then R8 must not forward from a faulted result
      op(1'b1, 64'h20, 9'h3, 64'h1234, 5'd6, 64'h99, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
      op(1'b1, 64'h20, 9'h3, 64'h5678, 5'd6, 64'h99, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      op(1'b1, 64'h20, 9'h3, 64'h9ABC, 5'd6, 64'h99, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      op(1'b1, 64'h21, 9'h0, 64'hDEF0, 5'd6, 64'h99, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);

      // mixed traffic on a small destination set
      for (int i = 0; i < 600; i++) begin
         logic [31:0] r;
         r = $urandom;
         op(r[0] | r[1], {$urandom, $urandom}, OFS_W'($urandom), {$urandom, $urandom},
            IDX_W'(r[3:2]), {$urandom, $urandom}, r[4], r[5], r[6],
            (r[9:7] != 3'd0), (r[12:10] != 3'd0), (r[14:13] != 2'd0));
      end
      op(1'b0, 64'h0, 9'h0, 64'h0, 5'd0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      cycle_check();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule